// File: doc/BRIEF.md
# Two-Level DMA Descriptor Chain Sequencer

This block is the control sequencer of one DMA channel. It walks descriptors stored in memory and starts one transfer for each of them. It does not move any payload itself. A chain has two levels. The lower level is a list of link descriptors. Each link descriptor names a source, a destination and a byte count, and points to the next link. The upper level is a chain of list descriptors. Each list descriptor points to the first link of its list and to the next list.

Software sets up the block before a run. It writes a starting link pointer, a starting list pointer and an extended-chaining enable, then pulses start. The sequencer then reads descriptor words one at a time over a valid/ready read port. For each link it hands the transfer parameters to an external data mover through a start/done handshake. After each transfer it follows the next pointers and stops when an end flag tells it to. A busy output and a sticky done flag report progress.

Top module: `dma_chain_seq`

## Requirements
- R1: After a synchronous active-low reset, `busy`, `done`, `xfer_start` and `rd_req_valid` are all low.
- R2: A start with extended chaining off reads four words from the programmed link pointer, with its low 5 bits cleared, at ascending addresses +0, +4, +8 and +12.
- R3: A start with extended chaining on first reads two words from the programmed list pointer, with its low 5 bits cleared: word +0 is the next-list pointer, whose bit 0 is the end-of-lists flag, and word +4 is the first link address. The block then fetches the link at that first link address with its low 5 bits cleared.
- R4: Each fetched link descriptor produces exactly one single-cycle `xfer_start`. At that pulse, `xfer_src`, `xfer_dst` and `xfer_len` equal the descriptor's words at offsets +0, +4 and +8. No further fetch begins until `xfer_done` has been seen.
- R5: When a transfer completes and bit 0 (end-of-links) of the link's word +12 is clear, the next link is fetched at word +12 with its low 5 bits cleared.
- R6: When end-of-links is set and extended chaining is off, the sequencer halts. It makes no further reads and starts no further transfers, even when more lists exist in memory.
- R7: When end-of-links is set, extended chaining is on and the end-of-lists flag of the current list is clear, the next list descriptor is read at the next-list pointer with its low 5 bits cleared.
- R8: When end-of-links is set, extended chaining is on and the end-of-lists flag is set, the sequencer halts.
- R9: At most one read is outstanding. A new request is issued only after the previous response arrives, and a request holds its address until it is accepted.
- R10: `busy` rises on the cycle after an accepted start and stays high until halt. `done` rises in the same cycle that `busy` falls and is cleared by the next accepted start. The two are never high together.
- R11: While `busy` is high, start pulses and configuration writes (select 0 = link pointer, 1 = list pointer, 2 = control with bit 0 as the extended enable) are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 2 | Register select: 0 link pointer, 1 list pointer, 2 control |
| cfg_wdata | input | ADDR_W | Configuration write data |
| sw_start | input | 1 | Start pulse |
| rd_req_valid | output | 1 | Read request valid |
| rd_req_ready | input | 1 | Read request accepted |
| rd_req_addr | output | ADDR_W | Read word address |
| rd_rsp_valid | input | 1 | Read response valid |
| rd_rsp_data | input | ADDR_W | Read response word |
| xfer_start | output | 1 | Single-cycle pulse that starts the data mover |
| xfer_src | output | ADDR_W | Transfer source address |
| xfer_dst | output | ADDR_W | Transfer destination address |
| xfer_len | output | ADDR_W | Transfer byte count |
| xfer_done | input | 1 | Data mover completion |
| busy | output | 1 | A run is in progress |
| done | output | 1 | The last run halted; cleared by the next start |

## Verification
Most internal faults in this block show up on the read address stream within a few cycles. A wrong pointer update, a flag test on the wrong bit or a missing alignment mask makes the next descriptor read go to the wrong address. The wrong address appears on `rd_req_addr` at the very next fetch. A wrong mode decision shows as either extra list reads or a halt that comes too early, and the transfer count exposes it by the time `done` rises. Errors in the word capture show on the transfer parameters at the first `xfer_start`.

// File: rtl/dcs_pkg.sv
// Shared types and constants for the descriptor chain sequencer.
// Assumes 32-bit-word descriptors with fixed word offsets.
package dcs_pkg;

    // Sequencer state encoding.
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_FETCH_LIST,
        ST_FETCH_LINK,
        ST_XFER,
        ST_CHECK_LINK,
        ST_CHECK_LIST,
        ST_HALT
    } seq_state_t;

    localparam int IDX_W      = 2;   // word index within a descriptor
    localparam int CNT_W      = 3;   // word count of a fetch
    localparam int LINK_WORDS = 4;
    localparam int LIST_WORDS = 2;

    // Word offsets inside a link descriptor.
    localparam logic [IDX_W-1:0] LK_SRC  = 2'd0;
    localparam logic [IDX_W-1:0] LK_DST  = 2'd1;
    localparam logic [IDX_W-1:0] LK_LEN  = 2'd2;
    localparam logic [IDX_W-1:0] LK_NEXT = 2'd3;

    // Word offsets inside a list descriptor.
    localparam logic [IDX_W-1:0] LS_NEXT  = 2'd0;
    localparam logic [IDX_W-1:0] LS_FIRST = 2'd1;

endpackage

// File: rtl/dcs_fetch.sv
// Descriptor word fetcher. On a go pulse it reads cnt consecutive words
// from base, one request at a time, and presents each response with its
// index. Assumes go arrives only while idle and cnt is 1..4.
module dcs_fetch
    import dcs_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              go,
    input  logic [ADDR_W-1:0] base,
    input  logic [CNT_W-1:0]  cnt,
    output logic              fetch_busy,
    output logic              rd_req_valid,
    input  logic              rd_req_ready,
    output logic [ADDR_W-1:0] rd_req_addr,
    input  logic              rd_rsp_valid,
    input  logic [ADDR_W-1:0] rd_rsp_data,
    output logic              word_vld,
    output logic [IDX_W-1:0]  word_idx,
    output logic [ADDR_W-1:0] word_data,
    output logic              word_last
);

    localparam int BYTES_PER_WORD = ADDR_W / 8;

    typedef enum logic [1:0] {F_IDLE, F_REQ, F_WAIT} fst_t;

    fst_t              fst;
    logic [ADDR_W-1:0] addr_q;
    logic [IDX_W-1:0]  idx_q;
    logic [IDX_W-1:0]  last_q;

    // Request, response and status decode from the fetch state.
    always_comb begin
        rd_req_valid = (fst == F_REQ);
        rd_req_addr  = addr_q;
        word_vld     = (fst == F_WAIT) && rd_rsp_valid;
        word_idx     = idx_q;
        word_data    = rd_rsp_data;
        word_last    = word_vld && (idx_q == last_q);
        fetch_busy   = (fst != F_IDLE);
    end

    // Sequences request, wait for response, then next word or finish.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fst    <= F_IDLE;
            addr_q <= '0;
            idx_q  <= '0;
            last_q <= '0;
        end else begin
            unique case (fst)
                F_IDLE: begin
                    if (go) begin
                        addr_q <= base;
                        idx_q  <= '0;
                        last_q <= IDX_W'(cnt - CNT_W'(1));
                        fst    <= F_REQ;
                    end
                end
                F_REQ: begin
                    if (rd_req_ready) fst <= F_WAIT;
                end
                F_WAIT: begin
                    if (rd_rsp_valid) begin
                        if (idx_q == last_q) begin
                            fst <= F_IDLE;
                        end else begin
                            idx_q  <= idx_q + IDX_W'(1);
                            addr_q <= addr_q + ADDR_W'(BYTES_PER_WORD);
                            fst    <= F_REQ;
                        end
                    end
                end
                default: fst <= F_IDLE;
            endcase
        end
    end

    AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req_valid && !rd_req_ready) |=> (rd_req_valid && $stable(rd_req_addr))); // R9

endmodule

// File: rtl/dcs_ptrs.sv
// Pointer and mode registers. Software writes them while the sequencer
// is idle. While the sequencer is busy only its own loads apply and
// software writes are dropped. Stored pointers are always aligned.
module dcs_ptrs
    import dcs_pkg::*;
#(
    parameter int ADDR_W    = 32,
    parameter int ALIGN_LSB = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sw_we,
    input  logic [1:0]        sw_sel,
    input  logic [ADDR_W-1:0] sw_wdata,
    input  logic              seq_busy,
    input  logic              ld_link,
    input  logic [ADDR_W-1:0] ld_link_val,
    input  logic              ld_list,
    input  logic [ADDR_W-1:0] ld_list_val,
    output logic [ADDR_W-1:0] cur_link,
    output logic [ADDR_W-1:0] cur_list,
    output logic              ext_en
);

    localparam logic [ADDR_W-1:0] PTR_MASK =
        {{(ADDR_W-ALIGN_LSB){1'b1}}, {ALIGN_LSB{1'b0}}};

    localparam logic [1:0] SEL_LINK = 2'd0;
    localparam logic [1:0] SEL_LIST = 2'd1;
    localparam logic [1:0] SEL_CTRL = 2'd2;

    // Applies sequencer loads when busy, otherwise software writes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_link <= '0;
            cur_list <= '0;
            ext_en   <= 1'b0;
        end else if (seq_busy) begin
            if (ld_link) cur_link <= ld_link_val & PTR_MASK;
            if (ld_list) cur_list <= ld_list_val & PTR_MASK;
        end else if (sw_we) begin
            unique case (sw_sel)
                SEL_LINK: cur_link <= sw_wdata & PTR_MASK;
                SEL_LIST: cur_list <= sw_wdata & PTR_MASK;
                SEL_CTRL: ext_en   <= sw_wdata[0];
                default: ;
            endcase
        end
    end

    AST_MODE_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        seq_busy |=> $stable(ext_en)); // R11

endmodule

// File: rtl/dcs_ctrl.sv
// Chain-walking state machine. It fetches list and link descriptors,
// starts a transfer per link, tests the end-of-links and end-of-lists
// flags (bit 0 of each next pointer) and halts. Assumes the mover raises
// done only after the start pulse it was given.
module dcs_ctrl
    import dcs_pkg::*;
#(
    parameter int ADDR_W    = 32,
    parameter int ALIGN_LSB = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sw_start,
    input  logic              ext_en,
    input  logic [ADDR_W-1:0] cur_link,
    input  logic [ADDR_W-1:0] cur_list,
    output logic              fetch_go,
    output logic [ADDR_W-1:0] fetch_base,
    output logic [CNT_W-1:0]  fetch_cnt,
    input  logic              fetch_busy,
    input  logic              word_vld,
    input  logic [IDX_W-1:0]  word_idx,
    input  logic [ADDR_W-1:0] word_data,
    input  logic              word_last,
    output logic              xfer_start,
    output logic [ADDR_W-1:0] xfer_src,
    output logic [ADDR_W-1:0] xfer_dst,
    output logic [ADDR_W-1:0] xfer_len,
    input  logic              xfer_done,
    output logic              ld_link,
    output logic [ADDR_W-1:0] ld_link_val,
    output logic              ld_list,
    output logic [ADDR_W-1:0] ld_list_val,
    output logic              busy,
    output logic              done
);

    localparam logic [ADDR_W-1:0] PTR_MASK =
        {{(ADDR_W-ALIGN_LSB){1'b1}}, {ALIGN_LSB{1'b0}}};

    seq_state_t        state;
    logic              go_q;
    logic [ADDR_W-1:0] base_q;
    logic [CNT_W-1:0]  cnt_q;
    logic [ADDR_W-1:0] nlist_q;
    logic [ADDR_W-1:0] src_q;
    logic [ADDR_W-1:0] dst_q;
    logic [ADDR_W-1:0] len_q;
    logic [ADDR_W-1:0] nlink_q;
    logic              xs_q;
    logic              done_q;

    // Drives the fetch request, mover outputs and status.
    always_comb begin
        fetch_go   = go_q;
        fetch_base = base_q;
        fetch_cnt  = cnt_q;
        xfer_start = xs_q;
        xfer_src   = src_q;
        xfer_dst   = dst_q;
        xfer_len   = len_q;
        busy       = (state != ST_IDLE);
        done       = done_q;
    end

    // Drives pointer register loads for link advance and list entry.
    always_comb begin
        ld_link     = 1'b0;
        ld_link_val = word_data;
        if (state == ST_CHECK_LINK) begin
            ld_link     = 1'b1;
            ld_link_val = nlink_q;
        end else if ((state == ST_FETCH_LIST) && word_vld && (word_idx == LS_FIRST)) begin
            ld_link     = 1'b1;
        end
        ld_list     = (state == ST_CHECK_LIST) && !nlist_q[0];
        ld_list_val = nlist_q;
    end

    // Main chain walk: state, descriptor capture and fetch launch.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= ST_IDLE;
            go_q    <= 1'b0;
            base_q  <= '0;
            cnt_q   <= '0;
            nlist_q <= '0;
            src_q   <= '0;
            dst_q   <= '0;
            len_q   <= '0;
            nlink_q <= '0;
            xs_q    <= 1'b0;
            done_q  <= 1'b0;
        end else begin
            go_q <= 1'b0;
            xs_q <= 1'b0;
            unique case (state)
                ST_IDLE: begin
                    if (sw_start) begin
                        done_q <= 1'b0;
                        go_q   <= 1'b1;
                        if (ext_en) begin
                            base_q <= cur_list;
                            cnt_q  <= CNT_W'(LIST_WORDS);
                            state  <= ST_FETCH_LIST;
                        end else begin
                            base_q <= cur_link;
                            cnt_q  <= CNT_W'(LINK_WORDS);
                            state  <= ST_FETCH_LINK;
                        end
                    end
                end
                ST_FETCH_LIST: begin
                    if (word_vld && (word_idx == LS_NEXT)) nlist_q <= word_data;
                    if (word_last) begin
                        go_q   <= 1'b1;
                        base_q <= word_data & PTR_MASK;
                        cnt_q  <= CNT_W'(LINK_WORDS);
                        state  <= ST_FETCH_LINK;
                    end
                end
                ST_FETCH_LINK: begin
                    if (word_vld) begin
                        unique case (word_idx)
                            LK_SRC:  src_q   <= word_data;
                            LK_DST:  dst_q   <= word_data;
                            LK_LEN:  len_q   <= word_data;
                            LK_NEXT: nlink_q <= word_data;
                            default: ;
                        endcase
                    end
                    if (word_last) begin
                        xs_q  <= 1'b1;
                        state <= ST_XFER;
                    end
                end
                ST_XFER: begin
                    if (xfer_done && !xs_q) state <= ST_CHECK_LINK;
                end
                ST_CHECK_LINK: begin
                    if (!nlink_q[0]) begin
                        go_q   <= 1'b1;
                        base_q <= nlink_q & PTR_MASK;
                        cnt_q  <= CNT_W'(LINK_WORDS);
                        state  <= ST_FETCH_LINK;
                    end else if (ext_en) begin
                        state <= ST_CHECK_LIST;
                    end else begin
                        state <= ST_HALT;
                    end
                end
                ST_CHECK_LIST: begin
                    if (!nlist_q[0]) begin
                        go_q   <= 1'b1;
                        base_q <= nlist_q & PTR_MASK;
                        cnt_q  <= CNT_W'(LIST_WORDS);
                        state  <= ST_FETCH_LIST;
                    end else begin
                        state <= ST_HALT;
                    end
                end
                ST_HALT: begin
                    done_q <= 1'b1;
                    state  <= ST_IDLE;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    AST_BUSY_DONE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(busy && done)); // R10
    AST_START_CLEARS_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        (sw_start && !busy) |=> (busy && !done)); // R10
    AST_GO_WHEN_FETCH_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        fetch_go |-> !fetch_busy); // R9
    AST_IDLE_NO_FETCH: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE) |-> !fetch_busy); // R6

endmodule

// File: rtl/dma_chain_seq.sv
// Top of the two-level descriptor chain sequencer: pointer registers,
// chain-walking control and the descriptor word fetcher. Assumes an
// external data mover honours the start/done handshake.
module dma_chain_seq
    import dcs_pkg::*;
#(
    parameter int ADDR_W    = 32,
    parameter int ALIGN_LSB = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [1:0]        cfg_sel,
    input  logic [ADDR_W-1:0] cfg_wdata,
    input  logic              sw_start,
    output logic              rd_req_valid,
    input  logic              rd_req_ready,
    output logic [ADDR_W-1:0] rd_req_addr,
    input  logic              rd_rsp_valid,
    input  logic [ADDR_W-1:0] rd_rsp_data,
    output logic              xfer_start,
    output logic [ADDR_W-1:0] xfer_src,
    output logic [ADDR_W-1:0] xfer_dst,
    output logic [ADDR_W-1:0] xfer_len,
    input  logic              xfer_done,
    output logic              busy,
    output logic              done
);

    logic [ADDR_W-1:0] cur_link;
    logic [ADDR_W-1:0] cur_list;
    logic              ext_en;
    logic              ld_link;
    logic [ADDR_W-1:0] ld_link_val;
    logic              ld_list;
    logic [ADDR_W-1:0] ld_list_val;
    logic              fetch_go;
    logic [ADDR_W-1:0] fetch_base;
    logic [CNT_W-1:0]  fetch_cnt;
    logic              fetch_busy;
    logic              word_vld;
    logic [IDX_W-1:0]  word_idx;
    logic [ADDR_W-1:0] word_data;
    logic              word_last;

    dcs_ptrs #(.ADDR_W(ADDR_W), .ALIGN_LSB(ALIGN_LSB)) u_ptrs (
        .clk         (clk),
        .rst_n       (rst_n),
        .sw_we       (cfg_we),
        .sw_sel      (cfg_sel),
        .sw_wdata    (cfg_wdata),
        .seq_busy    (busy),
        .ld_link     (ld_link),
        .ld_link_val (ld_link_val),
        .ld_list     (ld_list),
        .ld_list_val (ld_list_val),
        .cur_link    (cur_link),
        .cur_list    (cur_list),
        .ext_en      (ext_en)
    );

    dcs_ctrl #(.ADDR_W(ADDR_W), .ALIGN_LSB(ALIGN_LSB)) u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .sw_start    (sw_start),
        .ext_en      (ext_en),
        .cur_link    (cur_link),
        .cur_list    (cur_list),
        .fetch_go    (fetch_go),
        .fetch_base  (fetch_base),
        .fetch_cnt   (fetch_cnt),
        .fetch_busy  (fetch_busy),
        .word_vld    (word_vld),
        .word_idx    (word_idx),
        .word_data   (word_data),
        .word_last   (word_last),
        .xfer_start  (xfer_start),
        .xfer_src    (xfer_src),
        .xfer_dst    (xfer_dst),
        .xfer_len    (xfer_len),
        .xfer_done   (xfer_done),
        .ld_link     (ld_link),
        .ld_link_val (ld_link_val),
        .ld_list     (ld_list),
        .ld_list_val (ld_list_val),
        .busy        (busy),
        .done        (done)
    );

    dcs_fetch #(.ADDR_W(ADDR_W)) u_fetch (
        .clk          (clk),
        .rst_n        (rst_n),
        .go           (fetch_go),
        .base         (fetch_base),
        .cnt          (fetch_cnt),
        .fetch_busy   (fetch_busy),
        .rd_req_valid (rd_req_valid),
        .rd_req_ready (rd_req_ready),
        .rd_req_addr  (rd_req_addr),
        .rd_rsp_valid (rd_rsp_valid),
        .rd_rsp_data  (rd_rsp_data),
        .word_vld     (word_vld),
        .word_idx     (word_idx),
        .word_data    (word_data),
        .word_last    (word_last)
    );

    AST_XFER_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_start |=> !xfer_start); // R4
    AST_NO_READ_WHILE_XFER: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_start |-> !rd_req_valid); // R4

endmodule

// File: tb/tb_dma_chain_seq.sv
`timescale 1ns/1ps
module tb_dma_chain_seq;

    localparam int AW = 32;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          cfg_we;
    logic [1:0]    cfg_sel;
    logic [AW-1:0] cfg_wdata;
    logic          sw_start;
    logic          rd_req_valid;
    logic          rd_req_ready;
    logic [AW-1:0] rd_req_addr;
    logic          rd_rsp_valid;
    logic [AW-1:0] rd_rsp_data;
    logic          xfer_start;
    logic [AW-1:0] xfer_src;
    logic [AW-1:0] xfer_dst;
    logic [AW-1:0] xfer_len;
    logic          xfer_done;
    logic          busy;
    logic          done;

    always #2 clk = ~clk;   // 250 MHz

    dma_chain_seq dut (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
        .cfg_wdata(cfg_wdata), .sw_start(sw_start),
        .rd_req_valid(rd_req_valid), .rd_req_ready(rd_req_ready),
        .rd_req_addr(rd_req_addr), .rd_rsp_valid(rd_rsp_valid),
        .rd_rsp_data(rd_rsp_data), .xfer_start(xfer_start),
        .xfer_src(xfer_src), .xfer_dst(xfer_dst), .xfer_len(xfer_len),
        .xfer_done(xfer_done), .busy(busy), .done(done)
    );

    int errors = 0;
    int checks = 0;
    bit finished = 0;

    logic [31:0] mem [0:1023];

    // observed and expected streams
    logic [31:0] obs_addr [0:127];
    int          obs_an;
    logic [95:0] obs_x [0:31];
    int          obs_xn;
    logic [31:0] exp_addr [0:127];
    int          exp_an;
    logic [95:0] exp_x [0:31];
    int          exp_xn;
    int          proto_err;

    // chain layout
    logic [31:0] la [0:3];
    logic [31:0] lk [0:3][0:3];
    int          nk [0:3];

    task automatic check(input bit ok, input string req, input logic [95:0] act, input logic [95:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    endtask

    // memory responder: one outstanding read, random latency
    initial begin
        bit          pend;
        int          dly;
        logic [31:0] paddr;
        pend = 0; dly = 0; paddr = '0;
        rd_req_ready = 1'b0;
        rd_rsp_valid = 1'b0;
        rd_rsp_data  = '0;
        forever begin
            @(negedge clk);
            if (!rst_n) begin
                pend = 0; rd_req_ready = 1'b0; rd_rsp_valid = 1'b0;
            end else begin
                rd_req_ready = 1'b0;
                if (rd_rsp_valid) begin
                    rd_rsp_valid = 1'b0;
                    pend = 0;
                end
                if (pend && rd_req_valid) proto_err++;
                if (pend && !rd_rsp_valid) begin
                    if (dly == 0) begin
                        rd_rsp_valid = 1'b1;
                        rd_rsp_data  = mem[paddr[11:2]];
                    end else dly--;
                end else if (!pend && rd_req_valid && ($urandom % 4 != 0)) begin
                    rd_req_ready = 1'b1;
                    pend  = 1;
                    paddr = rd_req_addr;
                    dly   = int'($urandom % 3);
                    if (obs_an < 128) obs_addr[obs_an] = rd_req_addr;
                    obs_an++;
                end
            end
        end
    end

    // data mover model: logs each start, answers done after a delay
    initial begin
        int dcnt;
        dcnt = 0;
        xfer_done = 1'b0;
        forever begin
            @(negedge clk);
            if (!rst_n) begin
                dcnt = 0; xfer_done = 1'b0;
            end else begin
                if (xfer_done) xfer_done = 1'b0;
                if (dcnt > 0) begin
                    dcnt--;
                    if (dcnt == 0) xfer_done = 1'b1;
                end
                if (xfer_start) begin
                    if (dcnt > 0) proto_err++;
                    if (obs_xn < 32) obs_x[obs_xn] = {xfer_src, xfer_dst, xfer_len};
                    obs_xn++;
                    dcnt = 1 + int'($urandom % 4);
                end
            end
        end
    end

    // watchdog
    initial begin
        repeat (190000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        summary();
    end

    task automatic cfg_write(input logic [1:0] sel, input logic [31:0] val);
        @(negedge clk);
        cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = val;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic pulse_start();
        @(negedge clk);
        sw_start = 1'b1;
        @(negedge clk);
        sw_start = 1'b0;
    endtask

    function automatic logic [31:0] junk4();
        return ($urandom % 16) << 1;
    endfunction

    // Builds a two-level chain in memory and the expected streams.
    task automatic build(input bit ext, input int nl, input bit one_link);
        int slot;
        slot = int'($urandom % 4);
        for (int i = 0; i < nl; i++) begin
            la[i] = slot * 32; slot += 1 + int'($urandom % 3);
            nk[i] = one_link ? 1 : 1 + int'($urandom % 4);
            for (int j = 0; j < nk[i]; j++) begin
                lk[i][j] = slot * 32; slot += 1 + int'($urandom % 3);
            end
        end
        for (int i = 0; i < nl; i++) begin
            for (int j = 0; j < nk[i]; j++) begin
                mem[lk[i][j][11:2]]     = $urandom;
                mem[lk[i][j][11:2] + 1] = $urandom;
                mem[lk[i][j][11:2] + 2] = $urandom;
                mem[lk[i][j][11:2] + 3] = (j < nk[i] - 1) ? (lk[i][j+1] | junk4())
                                          : ((($urandom % 128) * 32) | junk4() | 32'd1);
            end
            mem[la[i][11:2]]     = (i < nl - 1) ? (la[i+1] | junk4())
                                   : ((($urandom % 128) * 32) | junk4() | 32'd1);
            mem[la[i][11:2] + 1] = lk[i][0] | ($urandom % 32);
        end
        exp_an = 0; exp_xn = 0;
        for (int i = 0; i < (ext ? nl : 1); i++) begin
            if (ext) begin
                exp_addr[exp_an] = la[i];     exp_an++;
                exp_addr[exp_an] = la[i] + 4; exp_an++;
            end
            for (int j = 0; j < nk[i]; j++) begin
                for (int w = 0; w < 4; w++) begin
                    exp_addr[exp_an] = lk[i][j] + 32'(w * 4); exp_an++;
                end
                exp_x[exp_xn] = {mem[lk[i][j][11:2]], mem[lk[i][j][11:2] + 1],
                                 mem[lk[i][j][11:2] + 2]};
                exp_xn++;
            end
        end
    endtask

    // Runs one chain and compares every stream against expectation.
    task automatic run(input bit ext, input int nl, input bit one_link, input bit poke);
        int t;
        string rq;
        build(ext, nl, one_link);
        cfg_write(2'd0, lk[0][0] | ($urandom % 32));
        cfg_write(2'd1, la[0] | ($urandom % 32));
        cfg_write(2'd2, {31'd0, ext});
        obs_an = 0; obs_xn = 0; proto_err = 0;
        pulse_start();
        @(negedge clk);
        check(busy && !done, "R10 busy/done after start", {busy, done}, 2'b10);
        if (poke) begin
            t = 0;
            while (obs_xn == 0 && t < 4000) begin @(negedge clk); t++; end
            pulse_start();                          // R11 start while busy
            cfg_write(2'd2, {31'd0, !ext});         // R11 mode write while busy
            cfg_write(2'd0, 32'h0000_0FE0);
        end
        t = 0;
        while (!done && t < 8000) begin @(negedge clk); t++; end
        check(done && !busy, "R10 halt status", {busy, done}, 2'b01);
        repeat (20) @(negedge clk);
        rq = ext ? "R8" : "R6";
        check(obs_an == exp_an, {rq, " read count at halt"}, obs_an, exp_an);
        check(obs_xn == exp_xn, {rq, " transfer count at halt"}, obs_xn, exp_xn);
        for (int k = 0; k < exp_an && k < obs_an; k++) begin
            rq = ext ? ((k < 2) ? "R3" : "R7") : ((k < 4) ? "R2" : "R5");
            if (poke) rq = "R11";
            check(obs_addr[k] == exp_addr[k], {rq, " read address"}, obs_addr[k], exp_addr[k]);
        end
        for (int k = 0; k < exp_xn && k < obs_xn; k++)
            check(obs_x[k] == exp_x[k], "R4 transfer parameters", obs_x[k], exp_x[k]);
        check(proto_err == 0, "R9 one outstanding read / R4 handshake", proto_err, 0);
        check(done && !busy && !rd_req_valid, "R10 quiet after halt", {busy, done, rd_req_valid}, 3'b010);
    endtask

    initial begin
        void'($urandom(32'd2024));
        rst_n = 1'b0; cfg_we = 1'b0; cfg_sel = '0; cfg_wdata = '0; sw_start = 1'b0;
        obs_an = 0; obs_xn = 0; proto_err = 0;
        for (int k = 0; k < 1024; k++) mem[k] = '0;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(!busy && !done && !xfer_start && !rd_req_valid, "R1 reset state",
              {busy, done, xfer_start, rd_req_valid}, 4'b0000);

        run(1'b0, 1, 1'b1, 1'b0);   // R2 single link, basic mode
        run(1'b0, 2, 1'b0, 1'b0);   // R6 more lists exist but mode is basic
        run(1'b1, 1, 1'b0, 1'b0);   // R8 one list, extended
        run(1'b1, 3, 1'b0, 1'b0);   // R7 three lists
        run(1'b1, 2, 1'b0, 1'b1);   // R11 start and writes while busy
        run(1'b0, 1, 1'b0, 1'b1);   // R11 in basic mode
        for (int n = 0; n < 8; n++)
            run(1'($urandom % 2), 1 + int'($urandom % 3), 1'b0, 1'($urandom % 2));

        summary();
    end

endmodule